// File: doc/BRIEF.md
# Lane Block-Execution Sequencer

This block sits beside one processing lane of a lockstep array. Normally the lane executes whatever instruction word the central controller broadcasts to every lane in the same cycle. The sequencer lets the lane take a private copy of a span of that stream and then run it on its own. It holds its own program counter and a small instruction buffer. While it runs locally it evaluates branches against a condition bit from its own datapath, so different lanes can take different paths and repeat loops a different number of times.

A capture command in the broadcast stream gives a word count. The sequencer stores that many following broadcast words in its buffer, starting at its current program counter. The broadcast word right after the captured span decides what happens next. A local branch starts local execution at its target. A barrier instruction leaves the words cached and parks the lane. Local execution ends at a barrier instruction, by running past the last captured word, or on an illegal branch target. The lane then holds a done level toward the controller until it gets a resume. A one-bit abort line from the controller overrides everything and returns the lane to broadcast mode.

Top module: `lane_useq`

## Requirements
- R1: After synchronous reset the program counter is 0 and local_mode, done and err are all low.
- R2: In broadcast mode an ordinary word (opcode bits [31:28] not 4'hD, 4'h5 or 4'hB) with bcast_valid high is issued unchanged on exec_instr with exec_valid high in the same cycle. Control words are never issued.
- R3: A capture command (opcode 4'hD, count in bits [15:0]) with a count from 1 to DEPTH stores the next count valid broadcast words at pc, pc+1, ... (modulo DEPTH). None of them is issued, and pc ends at the start address plus count.
- R4: A capture command with count 0 or larger than DEPTH sets err, leaves pc unchanged and starts no capture, so the following words pass through as in R2.
- R5: The first valid broadcast word after a capture is treated as follows. A local branch (opcode 4'hB, target in the low address bits, polarity in bit 16) whose polarity equals cond_flag enters local mode at its target. A local branch whose polarity differs has no effect. A barrier word (opcode 4'h5) sets done without changing pc.
- R6: Outside that one slot, barrier and local-branch words seen in broadcast mode have no effect on pc, done or local_mode.
- R7: In local mode the word at pc is fetched every cycle, an ordinary word is issued, and pc advances by one. Broadcast words are ignored. Advancing past the last captured word halts the lane with done high and pc equal to the start address plus count.
- R8: In local mode a taken local branch loads pc with its target, and a branch that is not taken advances pc by one. A barrier word halts the lane with done high and pc advanced past it.
- R9: A taken local branch whose target lies outside the captured span sets err and halts with done high, leaving pc at the branch.
- R10: While halted, done stays high and ordinary broadcast words are not issued. A resume returns the lane to broadcast mode on the next cycle, and a valid capture command is accepted directly.
- R11: Abort has the highest priority. On the next cycle the lane is in broadcast mode with done low, an ongoing capture stops without writing in the abort cycle, and no local word is issued in the abort cycle.
- R12: err stays high once set, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bcast_valid | input | 1 | Broadcast word present this cycle |
| bcast_instr | input | WORD_W | Broadcast instruction word |
| cond_flag | input | 1 | Branch condition from the lane datapath |
| resume | input | 1 | Controller releases a halted lane |
| abort | input | 1 | Controller forces broadcast mode |
| exec_valid | output | 1 | A word is issued to the lane datapath |
| exec_instr | output | WORD_W | Issued word |
| local_mode | output | 1 | Lane is running from its buffer |
| done | output | 1 | Lane is halted at a barrier |
| err | output | 1 | Sticky illegal-count or illegal-target flag |
| pc | output | log2(DEPTH) | Local program counter |

## Verification
The hardest states to reach from the ports are spans that wrap past the top of the buffer, and loops whose trip count depends on a condition bit that changes mid-run. The bench sweeps every legal count in a small buffer without resetting between runs, so each span starts where the last one stopped and the start address walks across the wrap point. Each span's local run is checked word by word against a start address and count that the bench computes. For loops, the bench watches the issued words and flips cond_flag after a chosen number of iterations. It then expects exactly that many passes and a final pc just past the barrier.

// File: rtl/lane_useq_pkg.sv
package lane_useq_pkg;

    localparam int unsigned OPC_W   = 4;
    localparam int unsigned ARG_W   = 16;
    localparam int unsigned POL_BIT = 16;

    localparam logic [OPC_W-1:0] OPC_CAPTURE = 4'hD;
    localparam logic [OPC_W-1:0] OPC_BARRIER = 4'h5;
    localparam logic [OPC_W-1:0] OPC_LBRANCH = 4'hB;

    typedef enum logic [1:0] {
        K_PLAIN,
        K_CAPTURE,
        K_BARRIER,
        K_LBRANCH
    } word_kind_e;

    typedef struct packed {
        word_kind_e       kind;
        logic [ARG_W-1:0] arg;
        logic             pol;
    } dec_t;

    typedef enum logic [1:0] {
        ST_BCAST,
        ST_CAPT,
        ST_LOCAL,
        ST_HALT
    } seq_state_e;

    function automatic logic count_legal(input logic [ARG_W-1:0] cnt,
                                         input int unsigned depth);
        return (cnt != '0) && (32'(cnt) <= depth);
    endfunction

endpackage

// File: rtl/lane_useq_decode.sv
module lane_useq_decode
    import lane_useq_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);

    logic [OPC_W-1:0] opc;

    assign opc = word[WORD_W-1 -: OPC_W];

    always_comb begin
        dec.arg = word[ARG_W-1:0];
        dec.pol = word[POL_BIT];
        case (opc)
            OPC_CAPTURE: dec.kind = K_CAPTURE;
            OPC_BARRIER: dec.kind = K_BARRIER;
            OPC_LBRANCH: dec.kind = K_LBRANCH;
            default:     dec.kind = K_PLAIN;
        endcase
    end

endmodule

// File: rtl/lane_useq_ibuf.sv
module lane_useq_ibuf #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/lane_useq_ctrl.sv
module lane_useq_ctrl
    import lane_useq_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned SPAN_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bcast_valid,
    input  dec_t              bdec,
    input  dec_t              ldec,
    input  logic              cond_flag,
    input  logic              resume,
    input  logic              abort,
    output seq_state_e        state,
    output logic [ADDR_W-1:0] pc,
    output logic              wr_en,
    output logic              err
);

    logic [ADDR_W-1:0] base;
    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] left;
    logic              armed;

    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] b_tgt;
    logic [ADDR_W-1:0] l_tgt;
    logic              b_taken;
    logic              l_taken;
    logic              b_tgt_ok;
    logic              l_tgt_ok;
    logic              last_word;
    logic              cap_seen;
    logic              cap_ok;

    // Offset from the span start, modulo the buffer size, compared to the count.
    function automatic logic in_span(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] start,
                                     input logic [SPAN_W-1:0] len);
        logic [ADDR_W-1:0] off;
        off = addr - start;
        return {1'b0, off} < len;
    endfunction

    always_comb begin
        pc_inc    = pc + ADDR_W'(1);
        b_tgt     = ADDR_W'(bdec.arg);
        l_tgt     = ADDR_W'(ldec.arg);
        b_taken   = (cond_flag == bdec.pol);
        l_taken   = (cond_flag == ldec.pol);
        b_tgt_ok  = in_span(b_tgt, base, span);
        l_tgt_ok  = in_span(l_tgt, base, span);
        last_word = ({1'b0, pc - base} + SPAN_W'(1)) == span;
        cap_seen  = bcast_valid && (bdec.kind == K_CAPTURE);
        cap_ok    = count_legal(bdec.arg, DEPTH);
        wr_en     = (state == ST_CAPT) && bcast_valid && !abort;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_BCAST;
            pc    <= '0;
            base  <= '0;
            span  <= '0;
            left  <= '0;
            armed <= 1'b0;
            err   <= 1'b0;
        end else if (abort) begin
            state <= ST_BCAST;
            armed <= 1'b0;
        end else begin
            unique case (state)
                ST_BCAST, ST_HALT: begin
                    if (cap_seen) begin
                        armed <= 1'b0;
                        if (cap_ok) begin
                            state <= ST_CAPT;
                            base  <= pc;
                            span  <= SPAN_W'(bdec.arg);
                            left  <= SPAN_W'(bdec.arg);
                        end else begin
                            err <= 1'b1;
                        end
                    end else if (state == ST_HALT) begin
                        if (resume) begin
                            state <= ST_BCAST;
                        end
                    end else if (bcast_valid && armed) begin
                        armed <= 1'b0;
                        if (bdec.kind == K_BARRIER) begin
                            state <= ST_HALT;
                        end else if (bdec.kind == K_LBRANCH && b_taken) begin
                            if (b_tgt_ok) begin
                                state <= ST_LOCAL;
                                pc    <= b_tgt;
                            end else begin
                                err   <= 1'b1;
                                state <= ST_HALT;
                            end
                        end
                    end
                end
                ST_CAPT: begin
                    if (bcast_valid) begin
                        pc   <= pc_inc;
                        left <= left - SPAN_W'(1);
                        if (left == SPAN_W'(1)) begin
                            state <= ST_BCAST;
                            armed <= 1'b1;
                        end
                    end
                end
                ST_LOCAL: begin
                    if (ldec.kind == K_BARRIER) begin
                        pc    <= pc_inc;
                        state <= ST_HALT;
                    end else if (ldec.kind == K_LBRANCH && l_taken) begin
                        if (l_tgt_ok) begin
                            pc <= l_tgt;
                        end else begin
                            err   <= 1'b1;
                            state <= ST_HALT;
                        end
                    end else begin
                        pc <= pc_inc;
                        if (last_word) begin
                            state <= ST_HALT;
                        end
                    end
                end
                default: state <= ST_BCAST;
            endcase
        end
    end

    // R12: the error flag never falls without reset
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R11: abort always lands in broadcast mode
    a_r11_abort_exit: assert property (@(posedge clk) disable iff (rst)
        abort |=> (state == ST_BCAST));

    // R7: local fetch never leaves the captured span
    a_r7_pc_in_span: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCAL) |-> in_span(pc, base, span));

    // R10: a halted lane stays halted until resume, abort or capture
    a_r10_halt_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && !abort && !resume && !cap_seen) |=> (state == ST_HALT));

    // R4: a rejected count keeps pc and mode
    a_r4_reject_keeps_pc: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BCAST && cap_seen && !cap_ok && !abort)
        |=> (state == ST_BCAST && $stable(pc)));

    // R3: each captured word advances pc by one
    a_r3_capture_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAPT && bcast_valid && !abort) |=> (pc == $past(pc_inc)));

endmodule

// File: rtl/lane_useq.sv
module lane_useq
    import lane_useq_pkg::*;
#(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bcast_valid,
    input  logic [WORD_W-1:0] bcast_instr,
    input  logic              cond_flag,
    input  logic              resume,
    input  logic              abort,
    output logic              exec_valid,
    output logic [WORD_W-1:0] exec_instr,
    output logic              local_mode,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] pc
);

    dec_t              bdec;
    dec_t              ldec;
    logic [WORD_W-1:0] lword;
    logic              wr_en;
    seq_state_e        state;

    lane_useq_decode #(.WORD_W(WORD_W)) u_bdec (
        .word (bcast_instr),
        .dec  (bdec)
    );

    lane_useq_ibuf #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ibuf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (pc),
        .wr_data (bcast_instr),
        .rd_addr (pc),
        .rd_data (lword)
    );

    lane_useq_decode #(.WORD_W(WORD_W)) u_ldec (
        .word (lword),
        .dec  (ldec)
    );

    lane_useq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .bcast_valid (bcast_valid),
        .bdec        (bdec),
        .ldec        (ldec),
        .cond_flag   (cond_flag),
        .resume      (resume),
        .abort       (abort),
        .state       (state),
        .pc          (pc),
        .wr_en       (wr_en),
        .err         (err)
    );

    always_comb begin
        local_mode = (state == ST_LOCAL);
        done       = (state == ST_HALT);
        exec_valid = 1'b0;
        exec_instr = bcast_instr;
        if (state == ST_LOCAL) begin
            exec_instr = lword;
            exec_valid = !abort && (ldec.kind == K_PLAIN);
        end else if (state == ST_BCAST) begin
            exec_valid = bcast_valid && (bdec.kind == K_PLAIN);
        end
    end

endmodule

// File: tb/lane_useq_tb.sv
module lane_useq_tb;

    localparam int unsigned DEPTH  = 16;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bcast_valid = 1'b0;
    logic [WORD_W-1:0] bcast_instr = '0;
    logic              cond_flag = 1'b0;
    logic              resume = 1'b0;
    logic              abort = 1'b0;
    logic              exec_valid;
    logic [WORD_W-1:0] exec_instr;
    logic              local_mode;
    logic              done;
    logic              err;
    logic [ADDR_W-1:0] pc;

    int checks = 0;
    int fails  = 0;
    int pc_m   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lane_useq #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_dut (
        .clk, .rst, .bcast_valid, .bcast_instr, .cond_flag, .resume, .abort,
        .exec_valid, .exec_instr, .local_mode, .done, .err, .pc
    );

    function automatic logic [31:0] w_plain(input int v);
        return {4'h1, 28'(v)};
    endfunction
    function automatic logic [31:0] w_cap(input int n);
        return {4'hD, 12'h0, 16'(n)};
    endfunction
    function automatic logic [31:0] w_bar();
        return {4'h5, 28'h0};
    endfunction
    function automatic logic [31:0] w_br(input logic pol, input int tgt);
        return {4'hB, 11'h0, pol, 16'(tgt)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] w);
        bcast_valid = v;
        bcast_instr = w;
        #1;
    endtask

    task automatic adv();
        @(negedge clk);
    endtask

    task automatic send(input logic [31:0] w);
        drive(1'b1, w);
        adv();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(1'b0, '0);
        adv(); adv();
        rst = 1'b0;
        pc_m = 0;
    endtask

    task automatic do_resume();
        drive(1'b0, '0);
        resume = 1'b1;
        adv();
        resume = 1'b0;
    endtask

    initial begin
        adv();
        do_reset();
        #1;
        // R1 reset state
        check("R1 pc", 32'(pc), 0);
        check("R1 local_mode", 32'(local_mode), 0);
        check("R1 done", 32'(done), 0);
        check("R1 err", 32'(err), 0);

        // R2 pass-through and control words withheld
        drive(1'b1, w_plain(7));
        check("R2 exec_valid", 32'(exec_valid), 1);
        check("R2 exec_instr", exec_instr, w_plain(7));
        drive(1'b1, w_bar());
        check("R2 barrier not issued", 32'(exec_valid), 0);
        adv();
        check("R6 barrier no effect", 32'(done), 0);
        cond_flag = 1'b1;
        send(w_br(1'b1, 0));
        check("R6 branch no effect local", 32'(local_mode), 0);
        check("R6 branch no effect pc", 32'(pc), 0);

        // R3 R5 R7 sweep over every legal count; spans wrap around the buffer
        for (int n = 1; n <= int'(DEPTH); n++) begin
            int base;
            logic pol;
            base = pc_m;
            pol  = logic'(n % 2);
            drive(1'b1, w_cap(n));
            check("R3 capture cmd not issued", 32'(exec_valid), 0);
            adv();
            for (int k = 0; k < n; k++) begin
                drive(1'b1, w_plain(n * 64 + k));
                check("R3 captured word not issued", 32'(exec_valid), 0);
                adv();
            end
            check("R3 pc after capture", 32'(pc), 32'((base + n) % int'(DEPTH)));
            cond_flag = pol;
            send(w_br(pol, base));
            check("R5 branch enters local", 32'(local_mode), 1);
            check("R5 branch target", 32'(pc), 32'(base));
            for (int k = 0; k < n; k++) begin
                drive(1'b1, w_plain(32'h0F00_0000));
                check("R7 local exec_valid", 32'(exec_valid), 1);
                check("R7 local word", exec_instr, w_plain(n * 64 + k));
                check("R7 local pc", 32'(pc), 32'((base + k) % int'(DEPTH)));
                adv();
            end
            check("R7 halt at span end", 32'(done), 1);
            check("R7 pc at halt", 32'(pc), 32'((base + n) % int'(DEPTH)));
            do_resume();
            check("R10 resume clears done", 32'(done), 0);
            pc_m = (base + n) % int'(DEPTH);
        end

        // R5 branch not taken in the slot after capture
        begin
            int base;
            base = pc_m;
            send(w_cap(3));
            for (int k = 0; k < 3; k++) send(w_plain(k));
            cond_flag = 1'b0;
            send(w_br(1'b1, base));
            check("R5 not taken local", 32'(local_mode), 0);
            check("R5 not taken pc", 32'(pc), 32'((base + 3) % int'(DEPTH)));
            drive(1'b1, w_plain(8'h55));
            check("R2 after slot", 32'(exec_valid), 1);
            adv();
            send(w_bar());
            check("R6 barrier after slot", 32'(done), 0);
            pc_m = (base + 3) % int'(DEPTH);
        end

        // R5 R10 barrier in the slot caches words and parks the lane
        begin
            int base;
            base = pc_m;
            send(w_cap(2));
            send(w_plain(1));
            send(w_plain(2));
            send(w_bar());
            check("R5 barrier sets done", 32'(done), 1);
            check("R5 barrier keeps pc", 32'(pc), 32'((base + 2) % int'(DEPTH)));
            drive(1'b1, w_plain(9));
            check("R10 halted not issued", 32'(exec_valid), 0);
            adv();
            check("R10 done held", 32'(done), 1);
            do_resume();
            check("R10 resumed", 32'(done), 0);
            pc_m = (base + 2) % int'(DEPTH);
        end

        // R8 data-dependent loop: three passes then exit to barrier
        begin
            int base;
            int iters;
            base  = pc_m;
            iters = 0;
            send(w_cap(3));
            send(w_plain(12'hA0));
            send(w_br(1'b0, base));
            send(w_bar());
            cond_flag = 1'b0;
            send(w_br(1'b0, base));
            for (int c = 0; c < 30; c++) begin
                drive(1'b0, '0);
                if (done) break;
                if (exec_valid && exec_instr == w_plain(12'hA0)) begin
                    iters++;
                    if (iters == 3) cond_flag = 1'b1;
                end
                adv();
            end
            check("R8 loop passes", 32'(iters), 3);
            check("R8 halt at barrier", 32'(done), 1);
            check("R8 pc past barrier", 32'(pc), 32'((base + 3) % int'(DEPTH)));
            check("R12 err still clear", 32'(err), 0);
            do_resume();
            pc_m = (base + 3) % int'(DEPTH);
        end

        // R9 taken branch outside the span
        begin
            int base;
            base = pc_m;
            send(w_cap(2));
            send(w_plain(3));
            send(w_br(1'b1, (base + 5) % int'(DEPTH)));
            cond_flag = 1'b1;
            send(w_br(1'b1, base));
            drive(1'b0, '0);
            adv();
            adv();
            check("R9 err set", 32'(err), 1);
            check("R9 halted", 32'(done), 1);
            check("R9 pc at branch", 32'(pc), 32'((base + 1) % int'(DEPTH)));
            do_resume();
            check("R12 err after resume", 32'(err), 1);
            abort = 1'b1;
            adv();
            abort = 1'b0;
            check("R12 err after abort", 32'(err), 1);
        end

        // R4 illegal counts
        do_reset();
        send(w_cap(0));
        check("R4 zero count err", 32'(err), 1);
        check("R4 zero count pc", 32'(pc), 0);
        drive(1'b1, w_plain(3));
        check("R4 next word passes", 32'(exec_valid), 1);
        adv();
        check("R4 no capture pc", 32'(pc), 0);
        do_reset();
        check("R1 err cleared", 32'(err), 0);
        send(w_cap(DEPTH + 1));
        check("R4 oversize err", 32'(err), 1);
        drive(1'b1, w_plain(4));
        check("R4 oversize passes", 32'(exec_valid), 1);
        adv();
        check("R4 oversize pc", 32'(pc), 0);

        // R11 abort out of a local loop
        do_reset();
        send(w_cap(1));
        send(w_br(1'b1, 0));
        cond_flag = 1'b1;
        send(w_br(1'b1, 0));
        adv(); adv();
        drive(1'b0, '0);
        check("R11 spinning local", 32'(local_mode), 1);
        abort = 1'b1;
        #1;
        check("R11 abort cycle silent", 32'(exec_valid), 0);
        adv();
        abort = 1'b0;
        #1;
        check("R11 left local", 32'(local_mode), 0);
        check("R11 done low", 32'(done), 0);
        drive(1'b1, w_plain(6));
        check("R11 broadcast again", 32'(exec_valid), 1);
        adv();

        // R11 abort during capture
        send(w_cap(4));
        send(w_plain(1));
        drive(1'b1, w_plain(2));
        abort = 1'b1;
        adv();
        abort = 1'b0;
        drive(1'b1, w_plain(8'h77));
        check("R11 capture stopped", 32'(exec_valid), 1);
        check("R11 capture pc", 32'(pc), 1);
        adv();

        // R10 capture accepted from the halted state
        send(w_cap(1));
        send(w_plain(8'hC1));
        send(w_bar());
        check("R10 parked", 32'(done), 1);
        check("R10 parked pc", 32'(pc), 2);
        send(w_cap(1));
        check("R10 capture from halt", 32'(done), 0);
        send(w_plain(8'hB1));
        cond_flag = 1'b1;
        send(w_br(1'b1, 2));
        drive(1'b0, '0);
        check("R10 runs new span", exec_instr, w_plain(8'hB1));
        check("R10 runs new span valid", 32'(exec_valid), 1);
        adv();
        check("R7 halt after new span", 32'(done), 1);
        check("R7 pc after new span", 32'(pc), 3);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule